// File: doc/BRIEF.md
# Sampled Event Tally with Byte-Window Readout

This block counts single-cycle pulses on an event input in a live counter of `CNT_W` bits (12 by default). A sample strobe copies the live count into a holding register and restarts the live count in the same clock edge. Software therefore always reads a stable snapshot: the number of events seen since the previous sample. A separate clear strobe discards the live count without taking a snapshot.

The snapshot is read through one narrow window of `WIN_W` bits (8 by default). A read-phase state machine picks which half the window shows. It has two states, `PH_LO` and `PH_HI`. In `PH_LO` the window shows the low byte of the snapshot. In `PH_HI` it shows the upper bits of the snapshot, zero-extended. Every window read strobe moves the machine to the other state: transition `READ_LO` goes from `PH_LO` to `PH_HI`, and transition `READ_HI` goes from `PH_HI` back to `PH_LO`. A snapshot therefore comes out low part first and high part second. The live counter has its own action decoder that picks one of four named actions each cycle: `ACT_IDLE`, `ACT_STEP`, `ACT_RESTART` and `ACT_WRAP`.

When an event carries the live count up to all ones, the block sets a sticky overflow flag and an interrupt-pending flag. The next event wraps the count to zero and counting carries on. The interrupt output is the pending flag gated by an enable bit that software writes.

Top module: `evt_tally_window`

## Requirements
- R1: After a synchronous active-high reset, `win_o`, `stat_o` and `irq_o` are all 0, and the live count, the snapshot and the read phase are 0.
- R2: Each cycle with `evt_i` high, and no sample or clear, adds one to the live count.
- R3: A sample strobe loads the live count into the snapshot and restarts the live count, so the next sample shows only the events that came later.
- R4: The snapshot, and therefore the window, does not change on events or clears. It changes only on a sample.
- R5: With the phase at 0, `win_o` equals snapshot bits [7:0]. With the phase at 1, `win_o[3:0]` equals snapshot bits [11:8] and `win_o[7:4]` reads 0.
- R6: The read phase is shown on `stat_o[3]`. It inverts on every `win_rd_i` strobe, and a sample does not change it.
- R7: A clear strobe sets the live count to 0, and the events counted before it are lost.
- R8: An event in the same cycle as a sample or a clear leaves the live count at 1.
- R9: An event that takes the live count from 0xFFE to 0xFFF sets the overflow flag `stat_o[0]` and the pending flag `stat_o[1]`. The next event takes the count to 0.
- R10: The overflow and pending flags stay set until a status write with a 1 in bit 0 or bit 1 clears that flag. A 0 in that bit leaves the flag as it is.
- R11: A status write loads the enable bit `stat_o[2]` from `stat_wdata_i[2]`. `irq_o` is high exactly when the pending flag and the enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Event pulse, counted once per high cycle |
| smp_i | input | 1 | Sample strobe: take a snapshot and restart the count |
| clr_i | input | 1 | Clear strobe for the live count |
| win_rd_i | input | 1 | Window read strobe; advances the read phase |
| win_o | output | WIN_W | Read window onto the snapshot |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | WIN_W | Status write data: bit0/bit1 write 1 to clear, bit2 enable |
| stat_o | output | WIN_W | Status: bit0 overflow, bit1 pending, bit2 enable, bit3 phase |
| irq_o | output | 1 | Interrupt request |

## Verification
Every stimulus takes effect at the first rising edge after it is driven. A sample, a read strobe or a status write therefore shows on `win_o`, `stat_o` or `irq_o` one cycle later, because those outputs are driven only from registers. The live count is not visible at the ports, so its effects show up only after a later sample. The bench drives inputs just after a falling edge and samples at the next falling edge, half a period after the edge that updated the registers. At that same falling edge a behavioural reference model, updated on the rising edge, is compared with all three outputs on every cycle.

// File: rtl/evt_tally_pkg.sv
package evt_tally_pkg;

    // read phase of the byte window
    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } phase_e;

    // what the live counter does in a cycle
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_STEP    = 2'd1,
        ACT_RESTART = 2'd2,
        ACT_WRAP    = 2'd3
    } cnt_act_e;

    // status bit positions
    localparam int ST_OVF  = 0;
    localparam int ST_PEND = 1;
    localparam int ST_EN   = 2;
    localparam int ST_PH   = 3;

endpackage

// File: rtl/tally_counter.sv
module tally_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_i,
    input  logic             smp_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);
    import evt_tally_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_MAX - 1'b1;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    cnt_act_e         act;

    // choose the counter action
    always_comb begin
        if (smp_i || clr_i)
            act = ACT_RESTART;
        else if (evt_i && (cnt_q == CNT_MAX))
            act = ACT_WRAP;
        else if (evt_i)
            act = ACT_STEP;
        else
            act = ACT_IDLE;
    end

    always_comb begin
        unique case (act)
            ACT_IDLE:    cnt_d = cnt_q;
            ACT_STEP:    cnt_d = cnt_q + 1'b1;
            ACT_RESTART: cnt_d = evt_i ? CNT_ONE : '0;
            ACT_WRAP:    cnt_d = '0;
            default:     cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign hit_o = (act == ACT_STEP) && (cnt_q == CNT_LAST);
    assign cnt_o = cnt_q;

endmodule

// File: rtl/hold_window.sv
module hold_window #(
    parameter int CNT_W = 12,
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             rd_i,
    output logic [CNT_W-1:0] hold_o,
    output logic             phase_o,
    output logic [WIN_W-1:0] win_o
);
    import evt_tally_pkg::*;

    localparam int HI_W = CNT_W - WIN_W;

    logic [CNT_W-1:0] hold_q;
    phase_e           ph_q;
    phase_e           ph_d;
    logic [WIN_W-1:0] hi_ext;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (smp_i)
            hold_q <= cnt_i;
    end

    // phase state register
    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= PH_LO;
        else
            ph_q <= ph_d;
    end

    // phase transitions: READ_LO and READ_HI
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_LO:   if (rd_i) ph_d = PH_HI;
            PH_HI:   if (rd_i) ph_d = PH_LO;
            default: ph_d = PH_LO;
        endcase
    end

    // window output
    always_comb begin
        hi_ext = '0;
        hi_ext[HI_W-1:0] = hold_q[CNT_W-1:WIN_W];
        unique case (ph_q)
            PH_LO:   win_o = hold_q[WIN_W-1:0];
            PH_HI:   win_o = hi_ext;
            default: win_o = '0;
        endcase
    end

    assign hold_o  = hold_q;
    assign phase_o = (ph_q == PH_HI);

endmodule

// File: rtl/tally_status.sv
module tally_status #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_i,
    input  logic             wr_i,
    input  logic [WIN_W-1:0] wdata_i,
    output logic             ovf_o,
    output logic             pend_o,
    output logic             en_o,
    output logic             irq_o
);
    import evt_tally_pkg::*;

    logic ovf_q, pend_q, en_q;
    logic ovf_clr, pend_clr;

    assign ovf_clr  = wr_i && wdata_i[ST_OVF];
    assign pend_clr = wr_i && wdata_i[ST_PEND];

    // a new overflow wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q  <= 1'b0;
            pend_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            ovf_q  <= hit_i || (ovf_q && !ovf_clr);
            pend_q <= hit_i || (pend_q && !pend_clr);
            if (wr_i)
                en_q <= wdata_i[ST_EN];
        end
    end

    assign ovf_o  = ovf_q;
    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign irq_o  = pend_q && en_q;

endmodule

// File: rtl/evt_tally_window.sv
module evt_tally_window #(
    parameter int CNT_W = 12,
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_i,
    input  logic             smp_i,
    input  logic             clr_i,
    input  logic             win_rd_i,
    output logic [WIN_W-1:0] win_o,
    input  logic             stat_wr_i,
    input  logic [WIN_W-1:0] stat_wdata_i,
    output logic [WIN_W-1:0] stat_o,
    output logic             irq_o
);
    import evt_tally_pkg::*;

    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] hold_w;
    logic             hit_w;
    logic             phase_w;
    logic             ovf_w, pend_w, en_w;

    tally_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt_i),
        .smp_i (smp_i),
        .clr_i (clr_i),
        .cnt_o (cnt_w),
        .hit_o (hit_w)
    );

    hold_window #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_win (
        .clk     (clk),
        .rst     (rst),
        .smp_i   (smp_i),
        .cnt_i   (cnt_w),
        .rd_i    (win_rd_i),
        .hold_o  (hold_w),
        .phase_o (phase_w),
        .win_o   (win_o)
    );

    tally_status #(.WIN_W(WIN_W)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .hit_i   (hit_w),
        .wr_i    (stat_wr_i),
        .wdata_i (stat_wdata_i),
        .ovf_o   (ovf_w),
        .pend_o  (pend_w),
        .en_o    (en_w),
        .irq_o   (irq_o)
    );

    always_comb begin
        stat_o          = '0;
        stat_o[ST_OVF]  = ovf_w;
        stat_o[ST_PEND] = pend_w;
        stat_o[ST_EN]   = en_w;
        stat_o[ST_PH]   = phase_w;
    end

endmodule

// File: rtl/evt_tally_chk.sv
module evt_tally_chk #(
    parameter int CNT_W = 12,
    parameter int WIN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             evt_i,
    input logic             smp_i,
    input logic             clr_i,
    input logic             win_rd_i,
    input logic             stat_wr_i,
    input logic [WIN_W-1:0] stat_wdata_i,
    input logic [WIN_W-1:0] win_o,
    input logic [WIN_W-1:0] stat_o,
    input logic             irq_o,
    input logic [CNT_W-1:0] cnt_w,
    input logic [CNT_W-1:0] hold_w
);
    localparam logic [CNT_W-1:0] C_MAX  = '1;
    localparam logic [CNT_W-1:0] C_LAST = C_MAX - 1'b1;
    localparam logic [CNT_W-1:0] C_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (evt_i && !smp_i && !clr_i && cnt_w != C_MAX) |=> cnt_w == $past(cnt_w) + 1'b1);

    p_sample_load_r3: assert property (@(posedge clk) disable iff (rst)
        smp_i |=> hold_w == $past(cnt_w));

    p_sample_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (smp_i && !evt_i) |=> cnt_w == '0);

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !smp_i |=> $stable(hold_w));

    p_hi_zero_r5: assert property (@(posedge clk) disable iff (rst)
        stat_o[3] |-> win_o[WIN_W-1:4] == '0);

    p_phase_flip_r6: assert property (@(posedge clk) disable iff (rst)
        win_rd_i |=> stat_o[3] != $past(stat_o[3]));

    p_phase_keep_r6: assert property (@(posedge clk) disable iff (rst)
        !win_rd_i |=> $stable(stat_o[3]));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !evt_i) |=> cnt_w == '0);

    p_keep_event_r8: assert property (@(posedge clk) disable iff (rst)
        ((smp_i || clr_i) && evt_i) |=> cnt_w == C_ONE);

    p_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (evt_i && !smp_i && !clr_i && cnt_w == C_LAST) |=> stat_o[0] && stat_o[1]);

    p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (evt_i && !smp_i && !clr_i && cnt_w == C_MAX) |=> cnt_w == '0);

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (stat_o[0] && !(stat_wr_i && stat_wdata_i[0])) |=> stat_o[0]);

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (stat_o[1] && stat_o[2]));

endmodule

bind evt_tally_window evt_tally_chk #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .evt_i        (evt_i),
    .smp_i        (smp_i),
    .clr_i        (clr_i),
    .win_rd_i     (win_rd_i),
    .stat_wr_i    (stat_wr_i),
    .stat_wdata_i (stat_wdata_i),
    .win_o        (win_o),
    .stat_o       (stat_o),
    .irq_o        (irq_o),
    .cnt_w        (cnt_w),
    .hold_w       (hold_w)
);

// File: tb/test_evt_tally_window.sv
module test_evt_tally_window;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt = 1'b0, smp = 1'b0, clr = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0] wdat = 8'h00;
    logic [7:0] win, stat;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;

    // reference model state
    int m_cnt = 0, m_hold = 0, m_ph = 0, m_ovf = 0, m_pend = 0, m_en = 0;

    always #10 clk = ~clk;

    evt_tally_window i_evt_tally_window (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (evt),
        .smp_i        (smp),
        .clr_i        (clr),
        .win_rd_i     (rd),
        .win_o        (win),
        .stat_wr_i    (wr),
        .stat_wdata_i (wdat),
        .stat_o       (stat),
        .irq_o        (irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            m_cnt = 0; m_hold = 0; m_ph = 0; m_ovf = 0; m_pend = 0; m_en = 0;
        end else begin
            bit hit;
            hit = evt && !smp && !clr && (m_cnt == 4094);
            if (smp) m_hold = m_cnt;
            if (smp || clr) m_cnt = evt ? 1 : 0;
            else if (evt) m_cnt = (m_cnt + 1) % 4096;
            if (rd) m_ph = 1 - m_ph;
            m_ovf  = (hit || (m_ovf  != 0 && !(wr && wdat[0]))) ? 1 : 0;
            m_pend = (hit || (m_pend != 0 && !(wr && wdat[1]))) ? 1 : 0;
            if (wr) m_en = wdat[2] ? 1 : 0;
        end
    end

    // compare every cycle
    always @(negedge clk) begin
        if (started) begin
            int exp_win;
            exp_win = (m_ph != 0) ? (m_hold >> 8) : (m_hold & 8'hFF);
            chk("R5 window vs model", int'(win), exp_win);
            chk("R10 status vs model", int'(stat), m_ovf + 2*m_pend + 4*m_en + 8*m_ph);
            chk("R11 irq vs model", int'(irq), (m_pend != 0 && m_en != 0) ? 1 : 0);
        end
    end

    task automatic step(input bit e, input bit s, input bit c, input bit r,
                        input bit w, input logic [7:0] wd);
        evt = e; smp = s; clr = c; rd = r; wr = w; wdat = wd;
        @(posedge clk);
        @(negedge clk);
        evt = 0; smp = 0; clr = 0; rd = 0; wr = 0; wdat = 8'h00;
    endtask

    task automatic events(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 8'h00);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 window after reset", int'(win), 0);
        chk("R1 status after reset", int'(stat), 0);
        chk("R1 irq after reset", int'(irq), 0);

        // R2 / R3: 300 events = 0x12C
        events(300);
        step(0, 1, 0, 0, 0, 8'h00);
        chk("R2 low byte of 300", int'(win), 8'h2C);
        step(0, 0, 0, 1, 0, 8'h00);
        chk("R6 phase after first read", int'(stat[3]), 1);
        chk("R5 high nibble of 300", int'(win), 8'h01);
        step(0, 0, 0, 1, 0, 8'h00);
        chk("R6 phase back to low", int'(stat[3]), 0);
        chk("R5 low byte again", int'(win), 8'h2C);

        // R3 restart and R6 phase kept over a sample
        step(0, 0, 0, 1, 0, 8'h00);
        step(0, 1, 0, 0, 0, 8'h00);
        chk("R3 count restarted by sample", int'(win), 0);
        chk("R6 sample keeps phase", int'(stat[3]), 1);
        step(0, 0, 0, 1, 0, 8'h00);

        // R4 and R7
        events(7);
        step(0, 1, 0, 0, 0, 8'h00);
        events(5);
        step(0, 0, 1, 0, 0, 8'h00);
        events(2);
        chk("R4 snapshot unchanged by events and clear", int'(win), 7);
        step(0, 1, 0, 0, 0, 8'h00);
        chk("R7 clear dropped earlier events", int'(win), 2);

        // R8
        events(4);
        step(1, 1, 0, 0, 0, 8'h00);
        chk("R8 sample takes pre-edge count", int'(win), 4);
        step(0, 1, 0, 0, 0, 8'h00);
        chk("R8 event with sample kept", int'(win), 1);
        events(3);
        step(1, 0, 1, 0, 0, 8'h00);
        step(0, 1, 0, 0, 0, 8'h00);
        chk("R8 event with clear kept", int'(win), 1);

        // R9 overflow at 0xFFF
        step(0, 0, 1, 0, 0, 8'h00);
        events(4094);
        chk("R9 no flag at 0xFFE", int'(stat[1:0]), 0);
        step(1, 0, 0, 0, 0, 8'h00);
        chk("R9 flags set at 0xFFF", int'(stat[1:0]), 3);
        chk("R11 irq held off while disabled", int'(irq), 0);
        events(2);
        step(0, 1, 0, 0, 0, 8'h00);
        chk("R9 count wrapped then stepped", int'(win), 1);
        chk("R10 flags still set", int'(stat[1:0]), 3);

        // R11 / R10
        step(0, 0, 0, 0, 1, 8'h04);
        chk("R11 irq once enabled", int'(irq), 1);
        step(0, 0, 0, 0, 1, 8'h05);
        chk("R10 only overflow cleared", int'(stat), 8'h06);
        chk("R11 irq stays with pending", int'(irq), 1);
        step(0, 0, 0, 0, 1, 8'h06);
        chk("R10 pending cleared", int'(stat), 8'h04);
        chk("R11 irq drops", int'(irq), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule